// File: doc/BRIEF.md
# Receive Status Trailer Appender

This block sits at the far end of a receive MAC datapath and forwards frame bytes on a byte-wide stream with valid, ready and last signals. While a frame passes through, it counts the accepted bytes and remembers any error pulses reported by the surrounding receive logic. The incoming end-of-frame marker is not forwarded. Once the frame's final byte has been accepted, the block appends four status bytes, and the last of these four carries the end marker.

The first two trailer bytes form a 16-bit status word, sent low byte first. Its upper four bits are error flags and its lower twelve bits hold the frame length. The third and fourth bytes are copies of two running statistics counters (runt frames and receive collisions), captured when the frame ends. While the trailer is being sent, no new input byte is accepted. Downstream backpressure is honoured on every byte.

Top module: `rx_status_trailer`

## Requirements
- R1: While no trailer is pending, out_valid equals in_valid, out_data equals in_data, in_ready equals out_ready, and out_last stays 0 (the input end marker is never forwarded).
- R2: After a byte with in_last is accepted, exactly four trailer bytes follow with out_valid high. out_last is 1 only on the fourth, and the block then returns to pass-through.
- R3: Trailer byte 0 is bits 7..0 and byte 1 is bits 15..8 of a status word. Bits 11..0 of that word hold the number of bytes accepted in the frame, including the final one.
- R4: Status word bit 15 means overflow, bit 14 collision, bit 13 framing error and bit 12 FCS error. A bit is 1 when its error input pulsed in any cycle from the end of the previous trailer up to and including the cycle the final byte was accepted.
- R5: Trailer byte 2 equals runt_count and byte 3 equals coll_count, both as sampled in the cycle the frame's final byte was accepted.
- R6: The length field saturates at 4095 for frames of 4095 bytes or more.
- R7: While the trailer is pending, in_ready is 0 and in_valid has no effect on the output.
- R8: A trailer byte stays on the output, unchanged, until it is taken with out_ready high.
- R9: Error pulses that arrive while the trailer is pending are ignored. The next frame starts with all flags clear and a zero length.
- R10: After reset the block is in pass-through with zero length and clear flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Incoming frame byte |
| in_valid | input | 1 | Incoming byte is valid |
| in_last | input | 1 | Incoming byte ends the frame |
| in_ready | output | 1 | Block accepts the incoming byte |
| err_overflow | input | 1 | Pulse: receive buffer overflow in this frame |
| err_collision | input | 1 | Pulse: collision seen in this frame |
| err_framing | input | 1 | Pulse: framing error in this frame |
| err_fcs | input | 1 | Pulse: FCS mismatch in this frame |
| runt_count | input | 8 | Running runt-frame counter value |
| coll_count | input | 8 | Running receive-collision counter value |
| out_data | output | 8 | Outgoing byte (frame or trailer) |
| out_valid | output | 1 | Outgoing byte is valid |
| out_last | output | 1 | Outgoing byte is the last trailer byte |
| out_ready | input | 1 | Downstream takes the outgoing byte |

## Verification
Random frames of varied length are driven with random input gaps, random downstream stalls, sparse error pulses and counter values that change every cycle. The gaps test pass-through against stalled trailers. The changing counters show whether the trailer uses the values sampled at frame end rather than live ones. Directed frames cover a one-byte frame with all four error pulses on its final byte, pulses injected only while a trailer is stalled (these must not reach the next frame), and frames of 4095 and 4100 bytes, which must give the same saturated length.

// File: rtl/rx_trailer_pkg.sv
// Package: shared widths and the status word packing for the trailer appender.
// Assumes byte-wide stream and a 16-bit word of flags over length.
package rx_trailer_pkg;
    localparam int LEN_W    = 12;
    localparam int FLAG_N   = 4;
    localparam int WORD_W   = LEN_W + FLAG_N;
    localparam int TRL_N    = 4;
    localparam int IDX_W    = $clog2(TRL_N);

    // Flag positions inside the flag nibble (bit 3 lands at word bit 15).
    localparam int FL_OVF   = 3;
    localparam int FL_COL   = 2;
    localparam int FL_FRM   = 1;
    localparam int FL_FCS   = 0;

    typedef logic [FLAG_N-1:0] flags_t;
    typedef logic [LEN_W-1:0]  len_t;

    // Pack flags above the length field.
    function automatic logic [WORD_W-1:0] pack_word(flags_t f, len_t n);
        return {f, n};
    endfunction
endpackage

// File: rtl/rx_frame_stats.sv
// Module: per-frame length counter and sticky error flags.
// Counts accepted bytes with saturation, ORs error pulses while not frozen,
// and clears both when the trailer completes. Assumes clear and count_en
// are never both high.
module rx_frame_stats
    import rx_trailer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   count_en,
    input  logic   freeze,
    input  logic   clear,
    input  flags_t err_pulse,
    output len_t   len_q,
    output flags_t flags_q
);
    localparam len_t LEN_MAX = '1;

    // Saturating byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            len_q <= '0;
        else if (count_en && len_q != LEN_MAX)
            len_q <= len_q + len_t'(1);
    end

    // Sticky error flags, frozen while the trailer is pending.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            flags_q <= '0;
        else if (!freeze)
            flags_q <= flags_q | err_pulse;
    end

    AST_LEN_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == LEN_MAX && !clear) |=> len_q == LEN_MAX) else $error("len wrapped"); // R6
    AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !clear) |=> $stable(flags_q)) else $error("flags moved"); // R9
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (len_q == '0 && flags_q == '0)) else $error("not cleared"); // R9
endmodule

// File: rtl/rx_trailer_seq.sv
// Module: trailer sequencer. Enters trailer mode when the final frame byte
// is accepted, steps a byte index on each downstream handshake and leaves
// after the last trailer byte. Assumes start only arrives in pass-through.
module rx_trailer_seq
    import rx_trailer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             out_ready,
    output logic             active,
    output logic [IDX_W-1:0] idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(TRL_N - 1);

    // Trailer completes when the final trailer byte is handed over.
    always_comb done = active && out_ready && idx == IDX_END;

    // Mode and byte index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (!active) begin
            active <= start;
            idx    <= '0;
        end else if (out_ready) begin
            active <= !done;
            idx    <= done ? '0 : idx + 1'b1;
        end
    end

    AST_START_TRL: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !active) |=> (active && idx == '0)) else $error("no trailer"); // R2
    AST_TRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !out_ready) |=> (active && $stable(idx))) else $error("advanced while stalled"); // R8
    AST_TRL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active) else $error("trailer overran"); // R2
endmodule

// File: rtl/rx_status_trailer.sv
// Module: top of the receive status trailer appender. Passes frame bytes
// through combinationally, drops the input end marker and appends four
// status bytes (word low, word high, runt count, collision count).
// Assumes upstream holds a byte stable until it is accepted.
module rx_status_trailer
    import rx_trailer_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              err_overflow,
    input  logic              err_collision,
    input  logic              err_framing,
    input  logic              err_fcs,
    input  logic [STAT_W-1:0] runt_count,
    input  logic [STAT_W-1:0] coll_count,
    output logic [7:0]        out_data,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready
);
    logic              active, done, accept, accept_end;
    logic [IDX_W-1:0]  idx;
    len_t              len_q;
    flags_t            flags_q, err_vec;
    logic [WORD_W-1:0] word;
    logic [STAT_W-1:0] runt_snap, coll_snap;

    // Collect the error pulses into the flag vector.
    always_comb begin
        err_vec         = '0;
        err_vec[FL_OVF] = err_overflow;
        err_vec[FL_COL] = err_collision;
        err_vec[FL_FRM] = err_framing;
        err_vec[FL_FCS] = err_fcs;
    end

    // Input handshake: blocked while the trailer is pending.
    always_comb begin
        in_ready   = out_ready && !active;
        accept     = in_valid && in_ready;
        accept_end = accept && in_last;
    end

    rx_frame_stats u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (accept),
        .freeze    (active),
        .clear     (done),
        .err_pulse (err_vec),
        .len_q     (len_q),
        .flags_q   (flags_q)
    );

    rx_trailer_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept_end),
        .out_ready (out_ready),
        .active    (active),
        .idx       (idx),
        .done      (done)
    );

    // Capture the statistics counters on the final frame byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            runt_snap <= '0;
            coll_snap <= '0;
        end else if (accept_end) begin
            runt_snap <= runt_count;
            coll_snap <= coll_count;
        end
    end

    always_comb word = pack_word(flags_q, len_q);

    // Output mux: frame bytes in pass-through, status bytes in trailer.
    always_comb begin
        if (!active) begin
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = 1'b0;
        end else begin
            out_valid = 1'b1;
            out_last  = (idx == IDX_W'(TRL_N - 1));
            case (idx)
                2'd0:    out_data = word[7:0];
                2'd1:    out_data = word[15:8];
                2'd2:    out_data = 8'(runt_snap);
                default: out_data = 8'(coll_snap);
            endcase
        end
    end

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !done) |=> ($stable(runt_snap) && $stable(coll_snap))) else $error("snapshot moved"); // R5
    AST_NO_LAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |-> !out_last) else $error("end marker forwarded"); // R1
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !out_ready) |=> (out_valid && $stable(out_data))) else $error("trailer byte changed"); // R8
    AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (active && in_valid) |=> $stable(len_q) || !active) else $error("input taken in trailer"); // R7
endmodule

// File: tb/rx_status_trailer_bench.sv
module rx_status_trailer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic       err_overflow = 0, err_collision = 0, err_framing = 0, err_fcs = 0;
    logic [7:0] runt_count = '0, coll_count = '0;
    logic [7:0] out_data;
    logic       out_valid, out_last;
    logic       out_ready = 1'b0;

    int n_chk = 0, n_fail = 0;

    // Bench reference state
    bit         m_trl = 0;
    int         m_idx = 0;
    int         m_len = 0;
    bit [3:0]   m_flags = 0;
    bit [7:0]   m_runt = 0, m_coll = 0;
    bit         m_stalled = 0;

    always #2 clk = ~clk;

    rx_status_trailer u_rx_status_trailer (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .err_overflow(err_overflow),
        .err_collision(err_collision), .err_framing(err_framing), .err_fcs(err_fcs),
        .runt_count(runt_count), .coll_count(coll_count), .out_data(out_data),
        .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Status word from the requirements: flags on top, length saturated.
    function automatic bit [15:0] exp_word(bit [3:0] f, int n);
        return {f, 12'(n > 4095 ? 4095 : n)};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One cycle: drive at negedge, compare just after, update reference.
    task automatic step(bit v, bit [7:0] d, bit l, bit [3:0] e, bit rdy, output bit acc);
        bit [15:0] w;
        bit [7:0]  eb;
        string     tag;
        @(negedge clk);
        in_valid = v; in_data = d; in_last = l; out_ready = rdy;
        {err_overflow, err_collision, err_framing, err_fcs} = e;
        runt_count = 8'($urandom); coll_count = 8'($urandom);
        #1;
        acc = 0;
        if (!m_trl) begin
            // R1 pass-through
            chk(out_valid == v && out_last == 0 && in_ready == rdy && (!v || out_data == d), "R1",
                {out_valid, out_last, in_ready, out_data}, {v, 1'b0, rdy, v ? d : out_data});
            m_flags |= e;
            if (v && rdy) begin
                acc = 1;
                m_len++;
                if (l) begin
                    m_trl = 1; m_idx = 0;
                    m_runt = runt_count; m_coll = coll_count;
                end
            end
        end else begin
            chk(in_ready == 0, "R7", in_ready, 0);
            chk(out_valid == 1 && out_last == (m_idx == 3), "R2",
                {out_valid, out_last}, {1'b1, m_idx == 3});
            w = exp_word(m_flags, m_len);
            case (m_idx)
                0: begin eb = w[7:0];  tag = (m_len >= 4095) ? "R6" : "R3"; end
                1: begin eb = w[15:8]; tag = (m_len >= 4095) ? "R6" : "R4"; end
                2: begin eb = m_runt;  tag = "R5"; end
                default: begin eb = m_coll; tag = "R5"; end
            endcase
            if (m_stalled) tag = "R8";
            chk(out_data == eb, tag, out_data, eb);
            m_stalled = !rdy;
            if (rdy) begin
                if (m_idx == 3) begin
                    m_trl = 0; m_len = 0; m_flags = 0;   // R9 clean restart
                end else m_idx++;
            end
        end
    endtask

    task automatic send_frame(int len, int pv, int pr, int pe, bit [3:0] fin_err);
        bit acc;
        for (int i = 0; i < len; i++) begin
            bit [7:0] b = 8'($urandom);
            do begin
                bit v = ($urandom % 100) < pv;
                bit r = ($urandom % 100) < pr;
                bit [3:0] e;
                for (int k = 0; k < 4; k++) e[k] = ($urandom % 1000) < pe;
                if (i == len - 1 && fin_err != 0) begin v = 1; r = 1; e = fin_err; end
                step(v, b, i == len - 1, e, r, acc);
            end while (!acc);
        end
    endtask

    task automatic drain(bit [3:0] e);
        bit acc;
        while (m_trl) step(1'b1, 8'hA5, 1'b0, e, 1'b1, acc);
    endtask

    initial begin
        #(180000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        bit acc;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: idle after reset, then a first frame whose word starts clean
        step(0, 8'h00, 0, 4'h0, 1, acc);
        chk(out_valid == 0 && in_ready == 1 && out_last == 0, "R10",
            {out_valid, in_ready, out_last}, 3'b010);
        send_frame(3, 100, 100, 0, 4'h0);
        drain(4'h0);

        // Directed: one-byte frame, all flags pulsed on its final byte (R4)
        send_frame(1, 100, 100, 0, 4'hF);
        drain(4'h0);

        // Directed: stalled trailer with input offered and pulses (R7, R8, R9)
        send_frame(5, 100, 100, 0, 4'h0);
        repeat (6) step(1, 8'h3C, 0, 4'hF, 0, acc);
        drain(4'hF);
        send_frame(4, 100, 100, 0, 4'h0);   // flags must read zero (R9)
        drain(4'h0);

        // Directed: saturation boundary (R6)
        send_frame(4095, 100, 100, 0, 4'h0);
        drain(4'h0);
        send_frame(4100, 100, 100, 0, 4'h0);
        drain(4'h0);

        // Random frames with gaps, stalls and sparse errors
        for (int f = 0; f < 300; f++)
            send_frame(1 + ($urandom % 40), 60 + ($urandom % 40), 50 + ($urandom % 50), 15, 4'h0);
        drain(4'h0);

        summary();
    end
endmodule